// File: doc/BRIEF.md
# I2C Slave with Clock-Stretch Wait Point

This block is the slave end of a two-wire serial bus. It watches SCL and SDA through synchronisers, spots start and stop conditions, compares an incoming 7-bit address with its own, and then moves data bytes in whichever direction the address byte's last bit asks for. Both lines are open-drain: the block only ever requests that a line be pulled low, and the surrounding pads combine that with the bus.

Its host logic is paced by clock stretching. At a chosen point in each byte the block keeps SCL low and raises a one-cycle interrupt. The host then reads the received byte, writes the next byte to send, or simply releases the wait. For received data the wait point can be placed after the 8th or the 9th clock. The wait is released either by a strobe or by writing all-ones to the data register. An acknowledge-enable input decides whether received bytes are acknowledged.

Top module: `i2c_wait_slave`

## Requirements
- R1: `start_flag` goes high when SDA falls while SCL is high, and is cleared by a stop. `stop_flag` goes high when SDA rises while SCL is high, and is cleared by a start. A stop releases both lines and ends any wait.
- R2: The address byte arrives MSB first: seven address bits, then a direction bit (1 = host reads, so the slave transmits). On a match the slave pulls SDA low during the 9th clock, and `tx_mode` takes the value of the direction bit.
- R3: On an address mismatch the slave gives no acknowledge, enters no wait, raises no interrupt and drives neither line until the next start or stop.
- R4: After an acknowledged address the slave never waits after the 8th clock. It always holds SCL low from the falling edge of the 9th clock.
- R5: For received data bytes, `wait_on_ninth` = 0 holds SCL low from the falling edge of the 8th clock. `wait_on_ninth` = 1 holds it low from the falling edge of the 9th clock. There is exactly one wait per byte.
- R6: `irq` is a single-cycle pulse, produced every time a wait begins.
- R7: In reception a wait ends on a `wait_release` pulse, or on a `data_wr` pulse with `data_wdata` = 8'hFF. A write of any other value leaves SCL held.
- R8: With `ack_enable` = 1 the slave pulls SDA low on the 9th clock of a received data byte; with 0 it leaves SDA released. `data_rdata` holds the last received data byte from its 8th rising SCL edge onward.
- R9: In transmission, a `data_wr` during the wait loads the byte and ends the wait, and the bits leave MSB first. After the 9th clock the slave waits again if the host acknowledged (SDA low). If the host did not acknowledge (SDA high), the slave ends the transfer and releases both lines with no wait.
- R10: A repeated start at any bit position clears the bit count and returns the slave to address reception.
- R11: During reset every output is low, or zero for buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad |
| scl_pull_low | output | 1 | Request to drive SCL low (clock stretch) |
| sda_pull_low | output | 1 | Request to drive SDA low |
| own_addr | input | 7 | Slave address to match |
| wait_on_ninth | input | 1 | Wait point for received data: 0 = after 8th clock, 1 = after 9th |
| ack_enable | input | 1 | Acknowledge received data bytes |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data written by host logic |
| data_rdata | output | 8 | Last received data byte |
| wait_release | input | 1 | Wait release strobe (reception) |
| start_flag | output | 1 | Start condition detected |
| stop_flag | output | 1 | Stop condition detected |
| tx_mode | output | 1 | Slave is transmitting (direction bit of matched address) |
| holding | output | 1 | Slave is in a wait, holding SCL low |
| irq | output | 1 | One-cycle pulse on entry to a wait |

## Verification
The assertions assume that the bus master keeps SCL low for several block clocks after each falling edge. They also assume that SDA changes only while SCL is low, except where a start or stop is intended. Without this, a wait could be seen to begin while SCL is already high again, or a data transition could be mistaken for a start or stop. The bench master drives every phase for eight clocks, and the synchroniser delay is about three. After raising SCL it waits for the line to go high before timing the high phase, so a stretch is never cut short.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_BITS = 7;
  localparam int CNT_W     = $clog2(BYTE_W + 2);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_RECV,
    PH_SEND
  } phase_t;

  // Address part of a received frame against the own address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [ADDR_BITS-1:0] own);
    return frame[BYTE_W-1 -: ADDR_BITS] == own;
  endfunction

  // All-ones write acts as a release in reception
  function automatic logic is_release_code(input logic [BYTE_W-1:0] d);
    return &d;
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/i2cw_core.sv
module i2cw_core
  import i2cw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic                 sda_s,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 wait_on_ninth,
  input  logic                 ack_enable,
  input  logic                 data_wr,
  input  logic [BYTE_W-1:0]    data_wdata,
  input  logic                 wait_release,
  output logic [BYTE_W-1:0]    data_rdata,
  output logic                 scl_pull_low,
  output logic                 sda_pull_low,
  output logic                 start_flag,
  output logic                 stop_flag,
  output logic                 tx_mode,
  output logic                 holding,
  output logic                 irq,
  output logic                 active
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  shreg, rx_q;
  logic               sda_low_q, hold_q, irq_q, trc_q, nack_q, start_q, stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rx_q      <= '0;
      sda_low_q <= 1'b0;
      hold_q    <= 1'b0;
      irq_q     <= 1'b0;
      trc_q     <= 1'b0;
      nack_q    <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start_evt) begin
        phase     <= PH_ADDR;
        cnt       <= '0;
        hold_q    <= 1'b0;
        sda_low_q <= 1'b0;
        start_q   <= 1'b1;
        stop_q    <= 1'b0;
      end else if (stop_evt) begin
        phase     <= PH_IDLE;
        cnt       <= '0;
        hold_q    <= 1'b0;
        sda_low_q <= 1'b0;
        stop_q    <= 1'b1;
        start_q   <= 1'b0;
      end else if (hold_q) begin
        if (phase == PH_SEND && data_wr) begin
          shreg     <= data_wdata;
          sda_low_q <= ~data_wdata[BYTE_W-1];
          hold_q    <= 1'b0;
        end else if (phase == PH_RECV &&
                     (wait_release || (data_wr && is_release_code(data_wdata)))) begin
          hold_q <= 1'b0;
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < LAST_BIT) begin
            cnt <= cnt + 1'b1;
            if (phase != PH_SEND) shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (phase == PH_RECV && cnt == LAST_BIT - 1'b1)
              rx_q <= {shreg[BYTE_W-2:0], sda_s};
          end else if (cnt == LAST_BIT) begin
            cnt    <= ACK_BIT;
            nack_q <= sda_s;
          end
        end else if (scl_fall) begin
          if (cnt == LAST_BIT) begin
            unique case (phase)
              PH_ADDR: begin
                if (addr_hit(shreg, own_addr)) begin
                  sda_low_q <= 1'b1;
                  trc_q     <= shreg[0];
                end else begin
                  phase     <= PH_IDLE;
                  sda_low_q <= 1'b0;
                end
              end
              PH_RECV: begin
                sda_low_q <= ack_enable;
                if (!wait_on_ninth) begin
                  hold_q <= 1'b1;
                  irq_q  <= 1'b1;
                end
              end
              default: sda_low_q <= 1'b0;
            endcase
          end else if (cnt == ACK_BIT) begin
            cnt       <= '0;
            sda_low_q <= 1'b0;
            unique case (phase)
              PH_ADDR: begin
                phase  <= trc_q ? PH_SEND : PH_RECV;
                hold_q <= 1'b1;
                irq_q  <= 1'b1;
              end
              PH_RECV: begin
                if (wait_on_ninth) begin
                  hold_q <= 1'b1;
                  irq_q  <= 1'b1;
                end
              end
              default: begin
                if (nack_q) phase <= PH_IDLE;
                else begin
                  hold_q <= 1'b1;
                  irq_q  <= 1'b1;
                end
              end
            endcase
          end else if (phase == PH_SEND && cnt != '0) begin
            shreg     <= {shreg[BYTE_W-2:0], 1'b0};
            sda_low_q <= ~shreg[BYTE_W-2];
          end
        end
      end
    end
  end

  assign data_rdata   = rx_q;
  assign scl_pull_low = hold_q;
  assign sda_pull_low = sda_low_q;
  assign start_flag   = start_q;
  assign stop_flag    = stop_q;
  assign tx_mode      = trc_q;
  assign holding      = hold_q;
  assign irq          = irq_q;
  assign active       = (phase != PH_IDLE);
endmodule

// File: rtl/i2c_wait_slave.sv
module i2c_wait_slave
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 scl_pull_low,
  output logic                 sda_pull_low,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 wait_on_ninth,
  input  logic                 ack_enable,
  input  logic                 data_wr,
  input  logic [BYTE_W-1:0]    data_wdata,
  output logic [BYTE_W-1:0]    data_rdata,
  input  logic                 wait_release,
  output logic                 start_flag,
  output logic                 stop_flag,
  output logic                 tx_mode,
  output logic                 holding,
  output logic                 irq
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_evt, stop_evt;
  logic       active;

  i2cw_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({scl_in, sda_in}),
    .synced (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cw_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cw_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .sda_s         (sda_s),
    .own_addr      (own_addr),
    .wait_on_ninth (wait_on_ninth),
    .ack_enable    (ack_enable),
    .data_wr       (data_wr),
    .data_wdata    (data_wdata),
    .wait_release  (wait_release),
    .data_rdata    (data_rdata),
    .scl_pull_low  (scl_pull_low),
    .sda_pull_low  (sda_pull_low),
    .start_flag    (start_flag),
    .stop_flag     (stop_flag),
    .tx_mode       (tx_mode),
    .holding       (holding),
    .irq           (irq),
    .active        (active)
  );
endmodule

// File: rtl/i2cw_checks.sv
module i2cw_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       scl_s,
  input logic       active,
  input logic       holding,
  input logic       irq,
  input logic       start_flag,
  input logic       stop_flag,
  input logic       sda_pull_low,
  input logic       scl_pull_low,
  input logic       tx_mode,
  input logic       wait_release,
  input logic       data_wr,
  input logic [7:0] data_wdata
);
  assert_start_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> start_flag && !stop_flag);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stop_flag && !holding && !sda_pull_low);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_pull_low && !scl_pull_low);

  assert_wait_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holding) |-> !scl_s);

  assert_irq_on_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holding) |-> irq);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_rx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !tx_mode && wait_release && !start_evt && !stop_evt) |=> !holding);

  assert_rx_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !tx_mode && data_wr && !(&data_wdata) && !wait_release
     && !start_evt && !stop_evt) |=> holding);
endmodule

bind i2c_wait_slave i2cw_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_evt    (start_evt),
  .stop_evt     (stop_evt),
  .scl_s        (scl_s),
  .active       (active),
  .holding      (holding),
  .irq          (irq),
  .start_flag   (start_flag),
  .stop_flag    (stop_flag),
  .sda_pull_low (sda_pull_low),
  .scl_pull_low (scl_pull_low),
  .tx_mode      (tx_mode),
  .wait_release (wait_release),
  .data_wr      (data_wr),
  .data_wdata   (data_wdata)
);

// File: tb/i2c_wait_slave_tb.sv
module i2c_wait_slave_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       wait_on_ninth = 1'b1, ack_enable = 1'b1;
  logic       data_wr = 1'b0, wait_release = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic       scl_pull_low, sda_pull_low, start_flag, stop_flag, tx_mode, holding, irq;
  logic [7:0] data_rdata;
  wire        scl_bus = m_scl & ~scl_pull_low;
  wire        sda_bus = m_sda & ~sda_pull_low;

  int vectors = 0, miscompares = 0, irq_cnt = 0;

  i2c_wait_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .own_addr(OWN), .wait_on_ninth(wait_on_ninth), .ack_enable(ack_enable),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .wait_release(wait_release), .start_flag(start_flag), .stop_flag(stop_flag),
    .tx_mode(tx_mode), .holding(holding), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_scl();
    m_scl = 1'b1;
    for (int g = 0; g < 2000 && !scl_bus; g++) tick(1);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); rise_scl(); tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q); rise_scl(); tick(Q/2); b = sda_bus; tick(Q/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic recv8(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      v[i] = b;
    end
  endtask

  task automatic do_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic host_write(input logic [7:0] v);
    data_wdata = v; data_wr = 1'b1; tick(1); data_wr = 1'b0; tick(2);
  endtask

  task automatic host_release();
    wait_release = 1'b1; tick(1); wait_release = 1'b0; tick(2);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] v;
    tick(3);
    // R11: reset values
    chk("R11 scl_pull_low", scl_pull_low, 0);
    chk("R11 sda_pull_low", sda_pull_low, 0);
    chk("R11 flags", {start_flag, stop_flag, tx_mode, holding, irq}, 0);
    chk("R11 data_rdata", data_rdata, 0);
    rst_n = 1'b1;
    tick(4);

    // Write transfer, wait at 9th
    do_start();
    chk("R1 start_flag", start_flag, 1);
    chk("R1 stop_flag", stop_flag, 0);
    send8({OWN, 1'b0});
    chk("R4 no wait after 8th on address", holding, 0);
    chk("R2 ack driven", sda_pull_low, 1);
    bit_in(a);
    chk("R2 address ack", a, 0);
    chk("R4 wait after 9th", holding, 1);
    chk("R2 tx_mode write", tx_mode, 0);
    chk("R6 irq count", irq_cnt, 1);
    host_release();
    chk("R7 strobe release", holding, 0);
    send8(8'hA5);
    chk("R5 no wait at 8th", holding, 0);
    bit_in(a);
    chk("R8 data ack", a, 0);
    chk("R5 wait at 9th", holding, 1);
    chk("R8 rdata", data_rdata, 8'hA5);
    chk("R6 irq count", irq_cnt, 2);
    host_write(8'hFF);
    chk("R7 FF release", holding, 0);

    // Wait at 8th
    wait_on_ninth = 1'b0;
    send8(8'h3C);
    chk("R5 wait at 8th", holding, 1);
    chk("R6 irq count", irq_cnt, 3);
    chk("R8 rdata at 8th", data_rdata, 8'h3C);
    chk("R8 ack held during wait", sda_pull_low, 1);
    host_write(8'h12);
    chk("R7 non-FF ignored", holding, 1);
    host_release();
    chk("R7 strobe release", holding, 0);
    bit_in(a);
    chk("R8 data ack", a, 0);
    chk("R5 single wait", holding, 0);

    // No acknowledge
    wait_on_ninth = 1'b1;
    ack_enable = 1'b0;
    send8(8'h55);
    bit_in(a);
    chk("R8 nack when disabled", a, 1);
    chk("R5 wait at 9th", holding, 1);
    chk("R6 irq count", irq_cnt, 4);
    host_release();
    ack_enable = 1'b1;
    do_stop();
    chk("R1 stop_flag", stop_flag, 1);
    chk("R1 start cleared", start_flag, 0);
    chk("R1 stop releases", {holding, sda_pull_low}, 0);

    // Address mismatch
    do_start();
    send8({7'h15, 1'b0});
    bit_in(a);
    chk("R3 no ack", a, 1);
    chk("R3 no wait", holding, 0);
    chk("R3 no irq", irq_cnt, 4);
    send8(8'h00);
    bit_in(a);
    chk("R3 ignores data", a, 1);
    chk("R3 no wait", holding, 0);
    do_stop();

    // Read transfer
    do_start();
    send8({OWN, 1'b1});
    bit_in(a);
    chk("R2 read ack", a, 0);
    chk("R4 wait after address", holding, 1);
    chk("R2 tx_mode read", tx_mode, 1);
    chk("R6 irq count", irq_cnt, 5);
    host_write(8'hC3);
    chk("R9 write releases", holding, 0);
    recv8(v);
    chk("R9 first byte", v, 8'hC3);
    bit_out(1'b0);
    chk("R9 wait after ack", holding, 1);
    chk("R6 irq count", irq_cnt, 6);
    host_write(8'h5A);
    recv8(v);
    chk("R9 second byte", v, 8'h5A);
    bit_out(1'b1);
    chk("R9 nack ends", holding, 0);
    chk("R9 sda released", sda_pull_low, 0);
    chk("R9 no irq", irq_cnt, 6);
    do_stop();

    // Repeated start mid-byte
    do_start();
    send8({OWN, 1'b0});
    bit_in(a);
    host_release();
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    do_start();
    chk("R10 start_flag", start_flag, 1);
    send8({OWN, 1'b1});
    bit_in(a);
    chk("R10 address ack", a, 0);
    chk("R10 tx_mode", tx_mode, 1);
    chk("R10 wait", holding, 1);
    host_write(8'h81);
    recv8(v);
    chk("R10 byte", v, 8'h81);
    bit_out(1'b1);
    do_stop();

    summary();
    $finish;
  end
endmodule